// File: doc/BRIEF.md
# Dual-Clock FIFO with Write-Side Reset Propagation

This block carries data words from a write clock domain to a read clock domain whose clock is unrelated to the write clock. The writer offers a word with `w_en` and the block takes it when `w_rdy` is high. The reader sees the oldest stored word on `r_data` whenever `r_rdy` is high, and takes it with `r_en`. Both pointers cross between the domains as Gray code through chains of flops. Full is computed on the write side and empty on the read side.

The write domain has two reset sources. One is an asynchronous, active-low power-on reset. The other is a synchronous, active-high soft reset that a host can pulse for one write clock. The block merges both into a single registered write-side reset. It passes that reset into the read domain through a synchronizer that asserts at once and releases after two read clock edges. Either source therefore empties the whole FIFO, read side included, so a parent block can use its own soft reset without leaving stale words readable.

Top module: `xclk_fifo`

## Requirements
- R1: A word is stored at a `wr_clk` rising edge where `w_en` and `w_rdy` are both high, and the stored words reach `r_data` in the order they were written, each exactly once.
- R2: `w_rdy` is low while `DEPTH` words are held, and a write attempted while `w_rdy` is low stores nothing and overwrites nothing.
- R3: The read port is show-ahead: while `r_rdy` is high, `r_data` already holds the oldest word, and a `rd_clk` rising edge with `r_en` high removes that word.
- R4: A read attempted while `r_rdy` is low changes no state: `r_rdy` stays low and later writes are read back correctly.
- R5: While `wr_rst_n` is low, `w_rdy` and `r_rdy` are both low, even if words were stored before. At the second `wr_clk` rising edge after release, `w_rdy` is high with the FIFO empty.
- R6: A `wr_srst` level sampled high at a `wr_clk` edge discards every stored word and drops any write offered in that cycle. `w_rdy` is low while `wr_srst` is high and during the cycle after it, and `w_rdy` is high again from the second `wr_clk` edge after `wr_srst` is sampled high.
- R7: After either write-side reset, `r_rdy` goes low and stays low until a new word is written, so no word written before the reset can be read.
- R8: Data moves correctly when `rd_clk` runs at twice the `wr_clk` frequency and also when it runs slower than `wr_clk`. The defaults are 8-bit words and a depth of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain power-on reset, asynchronous, active low |
| wr_srst | input | 1 | Write domain soft reset, synchronous to `wr_clk`, active high |
| w_en | input | 1 | Write request |
| w_data | input | DATA_W | Word to write |
| w_rdy | output | 1 | Write side can accept a word |
| rd_clk | input | 1 | Read domain clock |
| r_en | input | 1 | Read request, removes the word shown on `r_data` |
| r_data | output | DATA_W | Oldest stored word (show-ahead) |
| r_rdy | output | 1 | A word is available on `r_data` |

## Verification
The properties assume the following about the inputs. `wr_srst`, `w_en` and `w_data` change only away from `wr_clk` rising edges, and `r_en` changes only away from `rd_clk` rising edges. `wr_rst_n` may assert at any time but is released away from a `wr_clk` edge. Under these assumptions a one-cycle soft-reset pulse always arrives as a clean registered level in the read domain. The stimulus follows them: it drives write-side inputs and resets on falling `wr_clk` edges and `r_en` on falling `rd_clk` edges. The read clock starts at a phase offset, so no read edge lands on a write edge while a reset is in flight. Resets are applied only during the phase where the read clock runs at twice the write frequency.

// File: rtl/xclk_fifo_pkg.sv
`timescale 1ns/10ps
package xclk_fifo_pkg;

   localparam int GRAY_MAX_W = 32;

   function automatic logic [GRAY_MAX_W-1:0] bin2gray(input logic [GRAY_MAX_W-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [GRAY_MAX_W-1:0] gray2bin(input logic [GRAY_MAX_W-1:0] g);
      logic [GRAY_MAX_W-1:0] b;
      b[GRAY_MAX_W-1] = g[GRAY_MAX_W-1];
      for (int i = GRAY_MAX_W-2; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/xclk_fifo_sync.sv
`timescale 1ns/10ps
// Multi-flop synchronizer for a Gray-coded vector, with async and sync clear.
module xclk_fifo_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic         clr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int CHAIN_W = W * STAGES;

   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         chain <= '0;
      end else if (clr) begin
         chain <= '0;
      end else begin
         chain <= {chain[CHAIN_W-W-1:0], d};
      end
   end

   assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/xclk_fifo_rst_sync.sv
`timescale 1ns/10ps
// Reset bridge: asserts at once on arst, releases after STAGES clk edges.
module xclk_fifo_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst,
   output logic rst_n
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         chain <= '0;
      end else begin
         chain <= {chain[STAGES-2:0], 1'b1};
      end
   end

   assign rst_n = chain[STAGES-1];
endmodule

// File: rtl/xclk_fifo_wr_ctl.sv
`timescale 1ns/10ps
// Write side: reset merge, write pointer, full detection.
module xclk_fifo_wr_ctl
   import xclk_fifo_pkg::*;
#(
   parameter int AW = 1,
   parameter int PW = AW + 1
) (
   input  logic          wr_clk,
   input  logic          wr_rst_n,
   input  logic          wr_srst,
   input  logic          w_en,
   input  logic [PW-1:0] rgray_sync,
   output logic          w_rdy,
   output logic          push,
   output logic [AW-1:0] waddr,
   output logic [PW-1:0] wgray,
   output logic          wr_rst_q,
   output logic          wr_clr
);
   localparam logic [PW-1:0] FULL_FLIP = PW'(3) << (PW - 2);

   logic [PW-1:0] wbin;
   logic [PW-1:0] wbin_nx;
   logic          full;

   // Registered union of both write-side resets; this flop drives the read-side bridge.
   always_ff @(posedge wr_clk or negedge wr_rst_n) begin
      if (!wr_rst_n) begin
         wr_rst_q <= 1'b1;
      end else begin
         wr_rst_q <= wr_srst;
      end
   end

   assign wr_clr  = wr_srst | wr_rst_q;
   assign full    = (wgray == (rgray_sync ^ FULL_FLIP));
   assign w_rdy   = !full && !wr_clr;
   assign push    = w_en && w_rdy;
   assign wbin_nx = wbin + PW'(push);

   always_ff @(posedge wr_clk or negedge wr_rst_n) begin
      if (!wr_rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wr_clr) begin
         wbin  <= '0;
         wgray <= '0;
      end else begin
         wbin  <= wbin_nx;
         wgray <= PW'(bin2gray(GRAY_MAX_W'(wbin_nx)));
      end
   end

   assign waddr = wbin[AW-1:0];
endmodule

// File: rtl/xclk_fifo_rd_ctl.sv
`timescale 1ns/10ps
// Read side: read pointer and empty detection.
module xclk_fifo_rd_ctl
   import xclk_fifo_pkg::*;
#(
   parameter int AW = 1,
   parameter int PW = AW + 1
) (
   input  logic          rd_clk,
   input  logic          rd_rst_n,
   input  logic          r_en,
   input  logic [PW-1:0] wgray_sync,
   output logic          r_rdy,
   output logic [AW-1:0] raddr,
   output logic [PW-1:0] rgray
);
   logic [PW-1:0] rbin;
   logic [PW-1:0] rbin_nx;
   logic          pop;

   assign r_rdy   = (wgray_sync != rgray);
   assign pop     = r_en && r_rdy;
   assign rbin_nx = rbin + PW'(pop);

   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else begin
         rbin  <= rbin_nx;
         rgray <= PW'(bin2gray(GRAY_MAX_W'(rbin_nx)));
      end
   end

   assign raddr = rbin[AW-1:0];
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/10ps
module xclk_fifo #(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 2,
   parameter int SYNC_STAGES = 2,
   parameter int RST_STAGES  = 2
) (
   input  logic              wr_clk,
   input  logic              wr_rst_n,
   input  logic              wr_srst,
   input  logic              w_en,
   input  logic [DATA_W-1:0] w_data,
   output logic              w_rdy,
   input  logic              rd_clk,
   input  logic              r_en,
   output logic [DATA_W-1:0] r_data,
   output logic              r_rdy
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int PW = AW + 1;

   initial begin : param_guard
      assert (DATA_W >= 1) else $fatal(1, "xclk_fifo: DATA_W must be at least 1");
      assert (DEPTH >= 2 && (1 << AW) == DEPTH)
         else $fatal(1, "xclk_fifo: DEPTH must be a power of two, at least 2");
      assert (SYNC_STAGES >= 2) else $fatal(1, "xclk_fifo: SYNC_STAGES must be at least 2");
      assert (RST_STAGES >= 2) else $fatal(1, "xclk_fifo: RST_STAGES must be at least 2");
      assert (PW < 32) else $fatal(1, "xclk_fifo: DEPTH too large for pointer helpers");
   end

   logic              push;
   logic [AW-1:0]     waddr;
   logic [AW-1:0]     raddr;
   logic [PW-1:0]     wgray;
   logic [PW-1:0]     rgray;
   logic [PW-1:0]     rgray_w;
   logic [PW-1:0]     wgray_r;
   logic              wr_rst_q;
   logic              wr_clr;
   logic              rd_rst_n;
   logic [DEPTH*DATA_W-1:0] store;

   xclk_fifo_wr_ctl #(.AW(AW), .PW(PW)) u_wr (
      .wr_clk     (wr_clk),
      .wr_rst_n   (wr_rst_n),
      .wr_srst    (wr_srst),
      .w_en       (w_en),
      .rgray_sync (rgray_w),
      .w_rdy      (w_rdy),
      .push       (push),
      .waddr      (waddr),
      .wgray      (wgray),
      .wr_rst_q   (wr_rst_q),
      .wr_clr     (wr_clr)
   );

   xclk_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk    (wr_clk),
      .arst_n (wr_rst_n),
      .clr    (wr_clr),
      .d      (rgray),
      .q      (rgray_w)
   );

   xclk_fifo_rst_sync #(.STAGES(RST_STAGES)) u_rst_bridge (
      .clk   (rd_clk),
      .arst  (wr_rst_q),
      .rst_n (rd_rst_n)
   );

   xclk_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk    (rd_clk),
      .arst_n (rd_rst_n),
      .clr    (1'b0),
      .d      (wgray),
      .q      (wgray_r)
   );

   xclk_fifo_rd_ctl #(.AW(AW), .PW(PW)) u_rd (
      .rd_clk     (rd_clk),
      .rd_rst_n   (rd_rst_n),
      .r_en       (r_en),
      .wgray_sync (wgray_r),
      .r_rdy      (r_rdy),
      .raddr      (raddr),
      .rgray      (rgray)
   );

   // Storage: one register slice per entry, written in the write domain.
   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_entry
         always_ff @(posedge wr_clk) begin
            if (push && (waddr == AW'(e))) begin
               store[e*DATA_W +: DATA_W] <= w_data;
            end
         end
      end
   endgenerate

   assign r_data = store[raddr*DATA_W +: DATA_W];
endmodule

// File: rtl/xclk_fifo_chk.sv
`timescale 1ns/10ps
module xclk_fifo_chk
   import xclk_fifo_pkg::*;
#(
   parameter int PW    = 2,
   parameter int DEPTH = 2
) (
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          wr_rst_n,
   input logic          wr_srst,
   input logic          w_en,
   input logic          w_rdy,
   input logic          r_en,
   input logic          r_rdy,
   input logic [PW-1:0] wgray,
   input logic [PW-1:0] rgray,
   input logic [PW-1:0] rgray_w,
   input logic          wr_rst_q,
   input logic          rd_rst_n
);
   logic [PW-1:0] occ_w;
   assign occ_w = PW'(gray2bin(GRAY_MAX_W'(wgray))) - PW'(gray2bin(GRAY_MAX_W'(rgray_w)));

   AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      occ_w <= PW'(DEPTH)); // R2

   AST_FULL_WRITE_IGNORED: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (w_en && !w_rdy && !wr_srst && !wr_rst_q) |=> $stable(wgray)); // R2

   AST_EMPTY_READ_IGNORED: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (r_en && !r_rdy) |=> $stable(rgray)); // R4

   AST_SOFT_RST_CLEARS: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      wr_srst |=> (wgray == '0)); // R6

   AST_NO_STALE_AFTER_RST: assert property (@(posedge rd_clk) disable iff (!wr_rst_n)
      $rose(rd_rst_n) |-> !r_rdy); // R7

   AST_WPTR_ONE_BIT: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      !$past(wr_srst) |-> ($countones(wgray ^ $past(wgray)) <= 1)); // R8

   AST_RPTR_ONE_BIT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      $countones(rgray ^ $past(rgray)) <= 1); // R8
endmodule

bind xclk_fifo xclk_fifo_chk #(.PW(PW), .DEPTH(DEPTH)) u_chk (
   .wr_clk   (wr_clk),
   .rd_clk   (rd_clk),
   .wr_rst_n (wr_rst_n),
   .wr_srst  (wr_srst),
   .w_en     (w_en),
   .w_rdy    (w_rdy),
   .r_en     (r_en),
   .r_rdy    (r_rdy),
   .wgray    (wgray),
   .rgray    (rgray),
   .rgray_w  (rgray_w),
   .wr_rst_q (wr_rst_q),
   .rd_rst_n (rd_rst_n)
);

// File: tb/test_xclk_fifo.sv
`timescale 1ns/10ps
module test_xclk_fifo;
   localparam int DW    = 8;
   localparam int DEPTH = 2;

   logic          wr_clk   = 1'b0;
   logic          rd_clk   = 1'b0;
   logic          wr_rst_n = 1'b1;
   logic          wr_srst  = 1'b0;
   logic          w_en     = 1'b0;
   logic [DW-1:0] w_data   = '0;
   logic          r_en     = 1'b0;
   logic          w_rdy;
   logic          r_rdy;
   logic [DW-1:0] r_data;

   real           rd_half  = 1.25;
   int            n_chk    = 0;
   int            n_fail   = 0;
   bit            rd_on    = 1'b0;
   bit            poke_rd  = 1'b0;
   logic [DW-1:0] exp_q[$];

   xclk_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) i_xclk_fifo (
      .wr_clk   (wr_clk),
      .wr_rst_n (wr_rst_n),
      .wr_srst  (wr_srst),
      .w_en     (w_en),
      .w_data   (w_data),
      .w_rdy    (w_rdy),
      .rd_clk   (rd_clk),
      .r_en     (r_en),
      .r_data   (r_data),
      .r_rdy    (r_rdy)
   );

   // 200 MHz write clock; read clock starts at twice that rate with a phase offset.
   initial forever #2.5 wr_clk = ~wr_clk;
   initial begin
      #0.6;
      forever #(rd_half) rd_clk = ~rd_clk;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   // Driver: offer one word, record it as expected when it is accepted.
   task automatic put(input logic [DW-1:0] d);
      @(negedge wr_clk);
      while (!w_rdy) @(negedge wr_clk);
      w_en   = 1'b1;
      w_data = d;
      exp_q.push_back(d);
      @(negedge wr_clk);
      w_en   = 1'b0;
   endtask

   task automatic drain(input string req);
      int t = 0;
      while (exp_q.size() != 0 && t < 2000) begin
         @(negedge wr_clk);
         t++;
      end
      chk(exp_q.size() == 0, req, "all accepted words delivered", exp_q.size(), 0);
   endtask

   // Monitor: pops and compares on the read side; flags any offered word nobody wrote.
   initial forever begin
      @(negedge rd_clk);
      r_en = poke_rd;
      if (r_rdy) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7", "word offered with none outstanding", int'(r_data), -1);
         end else if (rd_on && ($urandom_range(3) != 0)) begin
            chk(r_data == exp_q[0], "R3", "show-ahead data in order", int'(r_data), int'(exp_q[0]));
            void'(exp_q.pop_front());
            r_en = 1'b1;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge wr_clk);
      chk(1'b0, "R1", "watchdog timeout", 0, 1);
      finish_run();
   end

   initial begin
      // R5: power-on reset state
      #1 wr_rst_n = 1'b0;
      repeat (4) @(negedge wr_clk);
      chk(w_rdy == 1'b0, "R5", "w_rdy held in reset", w_rdy, 0);
      chk(r_rdy == 1'b0, "R5", "r_rdy held in reset", r_rdy, 0);
      wr_rst_n = 1'b1;
      repeat (2) @(negedge wr_clk);
      chk(w_rdy == 1'b1, "R5", "w_rdy after reset release", w_rdy, 1);
      chk(r_rdy == 1'b0, "R5", "r_rdy empty after reset", r_rdy, 0);

      // R1 / R8: stream with read clock at twice the write clock
      rd_on = 1'b1;
      for (int i = 0; i < 40; i++) put(DW'($urandom));
      drain("R1");

      // R2: fill to DEPTH, then writes while full are dropped
      rd_on = 1'b0;
      for (int i = 0; i < DEPTH; i++) put(DW'(8'h30 + i));
      chk(w_rdy == 1'b0, "R2", "w_rdy low when full", w_rdy, 0);
      w_en = 1'b1; w_data = 8'hEE;
      repeat (4) @(negedge wr_clk);
      w_en = 1'b0;
      rd_on = 1'b1;
      drain("R2");
      repeat (20) @(negedge wr_clk);
      chk(r_rdy == 1'b0, "R2", "no extra word from write while full", r_rdy, 0);

      // R4: reads while empty are ignored
      rd_on = 1'b0;
      poke_rd = 1'b1;
      repeat (8) @(negedge wr_clk);
      poke_rd = 1'b0;
      chk(r_rdy == 1'b0, "R4", "r_rdy after reads on empty", r_rdy, 0);
      rd_on = 1'b1;
      put(8'hA5);
      put(8'h5A);
      drain("R4");

      // R6 / R7: soft reset with stored words and a concurrent write
      rd_on = 1'b0;
      put(8'h11);
      put(8'h22);
      repeat (6) @(negedge wr_clk);
      chk(r_rdy == 1'b1, "R1", "words visible before soft reset", r_rdy, 1);
      wr_srst = 1'b1; w_en = 1'b1; w_data = 8'h77;
      #0.1;
      chk(w_rdy == 1'b0, "R6", "w_rdy low while soft reset high", w_rdy, 0);
      @(negedge wr_clk);
      wr_srst = 1'b0; w_en = 1'b0;
      exp_q.delete();
      #0.1;
      chk(w_rdy == 1'b0, "R6", "w_rdy low cycle after soft reset", w_rdy, 0);
      chk(r_rdy == 1'b0, "R7", "read side cleared by soft reset", r_rdy, 0);
      @(negedge wr_clk);
      chk(w_rdy == 1'b1, "R6", "w_rdy back two clocks after pulse", w_rdy, 1);
      repeat (10) @(negedge wr_clk);
      chk(r_rdy == 1'b0, "R7", "no stale word after soft reset", r_rdy, 0);
      for (int i = 0; i < DEPTH; i++) put(DW'(8'h40 + i));
      chk(w_rdy == 1'b0, "R6", "full after exactly DEPTH new writes", w_rdy, 0);
      rd_on = 1'b1;
      drain("R7");

      // R5 / R7: power-on reset in the middle of operation
      rd_on = 1'b0;
      put(8'h33);
      repeat (6) @(negedge wr_clk);
      wr_rst_n = 1'b0;
      exp_q.delete();
      #1;
      chk(w_rdy == 1'b0, "R5", "w_rdy drops on async reset", w_rdy, 0);
      chk(r_rdy == 1'b0, "R5", "r_rdy drops on async reset", r_rdy, 0);
      @(negedge wr_clk);
      wr_rst_n = 1'b1;
      repeat (2) @(negedge wr_clk);
      chk(w_rdy == 1'b1, "R5", "w_rdy after mid-run reset", w_rdy, 1);
      repeat (10) @(negedge wr_clk);
      chk(r_rdy == 1'b0, "R7", "no stale word after hard reset", r_rdy, 0);

      // R8: read clock slower than the write clock
      rd_half = 3.3;
      rd_on = 1'b1;
      for (int i = 0; i < 30; i++) put(DW'($urandom));
      drain("R8");

      finish_run();
   end
endmodule